// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Protocol Engine

This block is the bus side of a byte-addressed serial EEPROM that only ever acts as a two-wire (I2C) slave. A system clock oversamples the clock and data lines through synchronizers and detects Start and Stop conditions from them. A select byte carries a fixed device type, three chip-enable bits and a direction bit. A write-mode select is followed by a two-byte address and then data bytes. A read-mode select returns bytes from a shared address counter. That counter keeps its value from one transaction to the next.

The engine reads storage through a synchronous byte port with one cycle of latency. Write traffic goes to a separate page-write sequencer as a push per accepted byte, then a commit pulse or a cancel pulse. The sequencer reports its internal write cycle on `wr_busy`. While `wr_busy` is high the engine acknowledges nothing, so a master can poll for completion by repeating Start and select. The data line is driven only through an active-high pull-down enable (`sda_oe`), in open-drain fashion.

Top module: `eep_slave_engine`

## Requirements
- R1: After reset `sda_oe` is 0. A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. Bits are taken on SCL rising edges, MSB first. A Stop returns the engine to standby with SDA released.
- R2: In the select byte, bits 7:4 must equal 4'b1010, bits 3:1 must equal `chip_en[2:0]`, and bit 0 gives the direction (1 = read, 0 = write). A select with both fields matching is acknowledged by holding `sda_oe` high through the 9th clock. A select with a different type code is not acknowledged.
- R3: When a select does not match, the engine does not acknowledge it and keeps SDA released until the next Start, whatever bytes are clocked in the meantime.
- R4: After a write-mode select, both address bytes are acknowledged. The high byte comes first, and the byte address is the low 13 bits of {high, low}. The top three bits of the high byte are ignored.
- R5: Each data byte that is accepted gives one `wr_push` pulse carrying `wr_addr` and `wr_data`, and the address counter then advances. A Stop seen after exactly one SCL rise following a data ACK (the 10th-bit slot) gives one `wr_commit` pulse.
- R6: During a write, only the low 5 bits of the counter advance. The byte after page offset 31 goes to offset 0 of the same 32-byte page.
- R7: While `wr_ctrl` is 1, the select and address bytes are still acknowledged. Data bytes get NoAck and cause no `wr_push` and no `wr_commit`. Reads behave the same whatever the level of `wr_ctrl`.
- R8: If bytes have been pushed and the write ends with a Stop outside the 10th-bit slot, or with a Start, the engine gives `wr_cancel` and no `wr_commit`.
- R9: A random read is a write select plus two address bytes, then a repeated Start and a read select. It returns the byte at that address, taken from `mem_rd_data` one cycle after `mem_rd_addr`.
- R10: A current-address read returns the byte at the counter value. That value is one past the last byte sent by the previous read, even across a Stop.
- R11: While the master acknowledges, a read keeps sending bytes from consecutive addresses. The counter wraps from 13'h1FFF to 13'h0000.
- R12: When the master answers a read byte with NoAck, the transfer ends. SDA stays released until the next Start.
- R13: While `wr_busy` is 1, nothing is acknowledged, not even a matching select.
- R14: A Start at any point abandons the current operation and begins select decoding again. `sda_oe` goes high only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired level) |
| sda_oe | output | 1 | 1 = pull the data line low |
| chip_en | input | 3 | Chip-enable value the select byte must carry in bits 3:1 |
| wr_ctrl | input | 1 | 1 = refuse all data bytes of writes |
| mem_rd_addr | output | 13 | Storage read address (the shared counter) |
| mem_rd_data | input | 8 | Storage read data, valid one cycle after the address |
| wr_busy | input | 1 | Internal write cycle in progress |
| wr_push | output | 1 | One-cycle pulse: an accepted data byte |
| wr_addr | output | 13 | Byte address of the pushed byte |
| wr_data | output | 8 | Pushed data byte |
| wr_commit | output | 1 | One-cycle pulse: start the internal write of the pushed bytes |
| wr_cancel | output | 1 | One-cycle pulse: discard the pushed bytes |

## Verification
Two things can land on the same oversampled cycle: the Stop detector firing, and the bit counter sitting at the 10th-bit slot of a write. Together they decide between commit and cancel. The bench places Stops right after a data ACK, after one extra clocked bit, and uses a repeated Start in place of a Stop. It judges each case by the commit and cancel pulse counts and by reading the storage back. A second overlap, a Start that arrives while `wr_busy` is high, is provoked by polling right after a commit and then again once the busy window has passed.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } eep_state_e;

    // Synchronized line levels and the events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

    function automatic logic sel_match(input logic [7:0] b, input logic [2:0] ce);
        return (b[7:4] == DEV_TYPE_CODE) && (b[3:1] == ce);
    endfunction

endpackage

// File: rtl/eep_line_sampler.sv
module eep_line_sampler
    import eep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] delayed;

    assign raw = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_line
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain      <= '1;
                    delayed[g] <= 1'b1;
                end else begin
                    chain      <= {chain[SYNC_STAGES-2:0], raw[g]};
                    delayed[g] <= chain[SYNC_STAGES-1];
                end
            end
            assign synced[g] = chain[SYNC_STAGES-1];
        end
    endgenerate

    always_comb begin
        ev.scl      = synced[0];
        ev.sda      = synced[1];
        ev.scl_rise = synced[0] & ~delayed[0];
        ev.scl_fall = ~synced[0] & delayed[0];
        ev.start    = synced[0] & delayed[0] & delayed[1] & ~synced[1];
        ev.stop     = synced[0] & delayed[0] & ~delayed[1] & synced[1];
    end

endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_full,
    input  logic              inc_page,
    output logic [ADDR_W-1:0] addr
);
    localparam int UPPER_W = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0]  low_next;
    logic [UPPER_W-1:0] upper;

    assign upper    = addr[ADDR_W-1:PAGE_W];
    assign low_next = addr[PAGE_W-1:0] + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (inc_full)
            addr <= addr + 1'b1;
        else if (inc_page)
            addr <= {upper, low_next};
    end

endmodule

// File: rtl/eep_xfer_fsm.sv
module eep_xfer_fsm
    import eep_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        chip_en,
    input  logic              wr_ctrl,
    input  logic              wr_busy,
    input  logic [7:0]        rd_data,
    input  logic [ADDR_W-1:0] addr_q,
    output logic              ctr_load,
    output logic [ADDR_W-1:0] ctr_load_val,
    output logic              ctr_inc_full,
    output logic              ctr_inc_page,
    output logic              sda_oe,
    output logic              wr_push,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              wr_cancel
);
    localparam int HI_W = ADDR_W - 8;

    eep_state_e      state;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg;
    logic [HI_W-1:0] hi_q;
    logic            ack_pend;
    logic            rw_q;
    logic            mack_q;
    logic            pend_q;
    logic [7:0]      rx_byte;
    logic            no_cond;
    logic            last_bit;

    assign rx_byte  = {shreg[6:0], ev.sda};
    assign no_cond  = ~ev.start & ~ev.stop;
    assign last_bit = ev.scl_rise && (bitcnt == 4'd7) && no_cond;

    always_comb begin
        ctr_load     = (state == ST_ALO) && last_bit;
        ctr_load_val = {hi_q, rx_byte};
        ctr_inc_page = (state == ST_WDAT) && last_bit && !wr_ctrl;
        ctr_inc_full = ev.scl_fall && no_cond &&
                       (((state == ST_DEV_ACK) && rw_q) || ((state == ST_RACK) && mack_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            hi_q      <= '0;
            ack_pend  <= 1'b0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            pend_q    <= 1'b0;
            sda_oe    <= 1'b0;
            wr_push   <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
            wr_cancel <= 1'b0;
        end else begin
            wr_push   <= 1'b0;
            wr_commit <= 1'b0;
            wr_cancel <= 1'b0;
            if (ev.start) begin
                sda_oe    <= 1'b0;
                bitcnt    <= '0;
                wr_cancel <= pend_q;
                pend_q    <= 1'b0;
                state     <= wr_busy ? ST_IDLE : ST_DEV;
            end else if (ev.stop) begin
                sda_oe    <= 1'b0;
                wr_commit <= pend_q && (state == ST_WDAT) && (bitcnt == 4'd1);
                wr_cancel <= pend_q && !((state == ST_WDAT) && (bitcnt == 4'd1));
                pend_q    <= 1'b0;
                state     <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                        if (ev.scl_rise) begin
                            shreg  <= rx_byte;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == 4'd7) begin
                                ack_pend <= 1'b1;
                                if (state == ST_DEV) begin
                                    rw_q <= rx_byte[0];
                                    if (!sel_match(rx_byte, chip_en) || wr_busy)
                                        state <= ST_IDLE;
                                end else if (state == ST_AHI) begin
                                    hi_q <= rx_byte[HI_W-1:0];
                                end else if (state == ST_WDAT) begin
                                    ack_pend <= !wr_ctrl;
                                    if (!wr_ctrl) begin
                                        wr_push <= 1'b1;
                                        wr_addr <= addr_q;
                                        wr_data <= rx_byte;
                                        pend_q  <= 1'b1;
                                    end
                                end
                            end
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            sda_oe <= ack_pend;
                            unique case (state)
                                ST_DEV:  state <= ST_DEV_ACK;
                                ST_AHI:  state <= ST_AHI_ACK;
                                ST_ALO:  state <= ST_ALO_ACK;
                                default: state <= ST_WDAT_ACK;
                            endcase
                        end
                    end
                    ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            unique case (state)
                                ST_DEV_ACK: begin
                                    if (rw_q) begin
                                        shreg  <= rd_data;
                                        sda_oe <= ~rd_data[7];
                                        state  <= ST_RDAT;
                                    end else begin
                                        state <= ST_AHI;
                                    end
                                end
                                ST_AHI_ACK: state <= ST_ALO;
                                default:    state <= ST_WDAT;
                            endcase
                        end
                    end
                    ST_RDAT: begin
                        if (ev.scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            mack_q <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack_q) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                bitcnt <= '0;
                                state  <= ST_RDAT;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: a Stop leaves the engine in standby with the line released
    p_stop_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(ev.stop) |-> (state == ST_IDLE) && !sda_oe);

    // R3 / R12: standby never drives the line
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R14: the pull-down only switches on while SCL is low
    p_oe_scl_low_r14: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(!ev.scl));

    // R7: a pushed byte never comes from a protected write
    p_push_wc_low_r7: assert property (@(posedge clk) disable iff (rst)
        wr_push |-> !$past(wr_ctrl));

    // R8: commit and cancel never together
    p_commit_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(wr_commit && wr_cancel));

    // R13: a Start during a busy write cycle leaves the engine silent
    p_busy_silent_r13: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_busy) && $past(ev.start)) |-> (state == ST_IDLE));

    // R11: each byte sent advances the shared counter by one, wrapping
    p_seq_inc_r11: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RDAT) && ($past(state) != ST_RDAT)) |->
        (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

    // R6: a write advance keeps the page bits
    p_page_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        $past(ctr_inc_page) |-> (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W])));

endmodule

// File: rtl/eep_slave_engine.sv
module eep_slave_engine
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        chip_en,
    input  logic              wr_ctrl,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    input  logic              wr_busy,
    output logic              wr_push,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              wr_cancel
);
    bus_ev_t           ev;
    logic [ADDR_W-1:0] addr_q;
    logic              ctr_load;
    logic [ADDR_W-1:0] ctr_load_val;
    logic              ctr_inc_full;
    logic              ctr_inc_page;

    eep_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    eep_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (ctr_load_val),
        .inc_full (ctr_inc_full),
        .inc_page (ctr_inc_page),
        .addr     (addr_q)
    );

    eep_xfer_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .chip_en      (chip_en),
        .wr_ctrl      (wr_ctrl),
        .wr_busy      (wr_busy),
        .rd_data      (mem_rd_data),
        .addr_q       (addr_q),
        .ctr_load     (ctr_load),
        .ctr_load_val (ctr_load_val),
        .ctr_inc_full (ctr_inc_full),
        .ctr_inc_page (ctr_inc_page),
        .sda_oe       (sda_oe),
        .wr_push      (wr_push),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_commit    (wr_commit),
        .wr_cancel    (wr_cancel)
    );

    assign mem_rd_addr = addr_q;

endmodule

// File: tb/eep_slave_engine_test.sv
module eep_slave_engine_test;
    localparam int Q      = 10;
    localparam int BUSY_N = 200;
    localparam logic [2:0] CE = 3'b101;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic        wr_ctrl = 1'b0;
    logic [12:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = 8'h00;
    logic        wr_busy;
    logic        wr_push, wr_commit, wr_cancel;
    logic [12:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int errors = 0;
    int push_cnt = 0, commit_cnt = 0, cancel_cnt = 0, busy_cnt = 0;
    logic [12:0] lp_addr;
    logic [7:0]  lp_data;
    logic [7:0]  model [int];
    int          pa[$];
    logic [7:0]  pd[$];
    logic [7:0]  rbuf [0:7];
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign wr_busy  = (busy_cnt != 0);

    eep_slave_engine uut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .chip_en(CE), .wr_ctrl(wr_ctrl), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .wr_busy(wr_busy), .wr_push(wr_push),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
        .wr_cancel(wr_cancel)
    );

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [12:0] a);
        if (model.exists(int'(a))) return model[int'(a)];
        return pat(a);
    endfunction

    // Storage stand-in and page-write sequencer stand-in
    always @(posedge clk) begin
        mem_rd_data <= exp_rd(mem_rd_addr);
        if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        if (wr_push) begin
            push_cnt++;
            lp_addr = wr_addr;
            lp_data = wr_data;
            pa.push_back(int'(wr_addr));
            pd.push_back(wr_data);
        end
        if (wr_commit) begin
            commit_cnt++;
            foreach (pa[i]) model[pa[i]] = pd[i];
            pa.delete();
            pd.delete();
            busy_cnt <= BUSY_N;
        end
        if (wr_cancel) begin
            cancel_cnt++;
            pa.delete();
            pd.delete();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic clk_bit(input logic b);
        sda_m = b;  tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        ack = (sda_line == 1'b0);
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl = 1'b0;
        end
        tick(Q);
        sda_m = ~mack; tick(Q);
        scl = 1'b1;    tick(2*Q);
        scl = 1'b0;
        sda_m = 1'b1;  tick(Q);
    endtask

    function automatic logic [7:0] sel(input logic rw);
        return {4'b1010, CE, rw};
    endfunction

    // Start, write select, two address bytes; ok = all three acknowledged
    task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo, output logic ok);
        logic a0, a1, a2;
        i2c_start();
        send_byte(sel(1'b0), a0);
        send_byte(hi, a1);
        send_byte(lo, a2);
        ok = a0 & a1 & a2;
    endtask

    task automatic read_random(input logic [7:0] hi, input logic [7:0] lo, input int n,
                               output logic ok);
        logic a0, a1;
        addr_phase(hi, lo, a0);
        i2c_start();
        send_byte(sel(1'b1), a1);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
        i2c_stop();
        ok = a0 & a1;
    endtask

    task automatic wait_idle();
        while (busy_cnt != 0) tick(1);
        tick(4);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ok, a;
        logic [7:0] b;
        int pc, cc, xc;
        int unsigned seed;
        seed = $urandom(32'h5eed);
        tick(5);
        rst = 1'b0;
        tick(5);

        // R1: reset state
        check(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);
        check(push_cnt == 0 && commit_cnt == 0, "R1 no pulses", push_cnt + commit_cnt, 0);

        // R2: matching select acknowledged, wrong type code not
        i2c_start(); send_byte(sel(1'b0), a); i2c_stop();
        check(a, "R2 match ack", a, 1);
        i2c_start(); send_byte({4'b1011, CE, 1'b0}, a); i2c_stop();
        check(!a, "R2 type mismatch", a, 0);

        // R3: chip-enable mismatch, then stays released
        i2c_start(); send_byte({4'b1010, ~CE, 1'b1}, a);
        check(!a, "R3 ce mismatch", a, 0);
        send_byte(8'h00, a);
        check(!a && !sda_oe, "R3 stays released", a, 0);
        i2c_stop();
        check(sda_oe == 1'b0, "R1 stop releases", sda_oe, 0);

        // R5: byte write with commit in the 10th-bit slot
        pc = push_cnt; cc = commit_cnt;
        addr_phase(8'h01, 8'h55, ok);
        send_byte(8'h3C, a);
        i2c_stop();
        check(ok && a, "R5 acks", {ok, a}, 3);
        check(push_cnt == pc + 1, "R5 one push", push_cnt - pc, 1);
        check(lp_addr == 13'h0155 && lp_data == 8'h3C, "R5 push content", {lp_addr, lp_data}, 21'h01553C);
        check(commit_cnt == cc + 1, "R5 commit", commit_cnt - cc, 1);

        // R13: poll while busy gets nothing, after busy gets ACK
        i2c_start(); send_byte(sel(1'b0), a); i2c_stop();
        check(!a, "R13 busy no ack", a, 0);
        wait_idle();
        i2c_start(); send_byte(sel(1'b0), a); i2c_stop();
        check(a, "R13 ack after busy", a, 1);

        // R9: random reads
        read_random(8'h01, 8'h55, 1, ok);
        check(ok && rbuf[0] == 8'h3C, "R9 written byte", rbuf[0], 8'h3C);
        read_random(8'h0A, 8'hBC, 1, ok);
        check(rbuf[0] == pat(13'h0ABC), "R9 untouched byte", rbuf[0], pat(13'h0ABC));

        // R4: top three address bits ignored
        read_random(8'hE1, 8'h55, 1, ok);
        check(ok && rbuf[0] == 8'h3C, "R4 upper bits ignored", rbuf[0], 8'h3C);

        // R6: page roll-over
        addr_phase(8'h0A, 8'h3E, ok);
        for (int i = 0; i < 4; i++) send_byte(8'h11 + 8'(i), a);
        i2c_stop();
        wait_idle();
        read_random(8'h0A, 8'h20, 2, ok);
        check(rbuf[0] == 8'h13 && rbuf[1] == 8'h14, "R6 wrap to page start",
              {rbuf[0], rbuf[1]}, 16'h1314);
        read_random(8'h0A, 8'h3E, 1, ok);
        check(rbuf[0] == 8'h11, "R6 first byte", rbuf[0], 8'h11);
        read_random(8'h0A, 8'h40, 1, ok);
        check(rbuf[0] == pat(13'h0A40), "R6 next page untouched", rbuf[0], pat(13'h0A40));

        // R7: write control
        wr_ctrl = 1'b1;
        pc = push_cnt; cc = commit_cnt;
        addr_phase(8'h02, 8'h00, ok);
        send_byte(8'h99, a);
        i2c_stop();
        check(ok, "R7 select/address acked", ok, 1);
        check(!a, "R7 data noack", a, 0);
        check(push_cnt == pc && commit_cnt == cc, "R7 no push/commit",
              push_cnt - pc + commit_cnt - cc, 0);
        read_random(8'h02, 8'h00, 1, ok);
        check(ok && rbuf[0] == pat(13'h0200), "R7 read unaffected", rbuf[0], pat(13'h0200));
        wr_ctrl = 1'b0;

        // R8: Stop outside the slot, and Start, both cancel
        cc = commit_cnt; xc = cancel_cnt;
        addr_phase(8'h03, 8'h00, ok);
        send_byte(8'h77, a);
        clk_bit(1'b0);
        i2c_stop();
        check(commit_cnt == cc && cancel_cnt == xc + 1, "R8 late stop cancels",
              cancel_cnt - xc, 1);
        addr_phase(8'h03, 8'h01, ok);
        send_byte(8'h55, a);
        i2c_start();
        i2c_stop();
        check(commit_cnt == cc && cancel_cnt == xc + 2, "R8 start cancels",
              cancel_cnt - xc, 2);
        read_random(8'h03, 8'h00, 2, ok);
        check(rbuf[0] == pat(13'h0300) && rbuf[1] == pat(13'h0301), "R8 storage unchanged",
              rbuf[0], pat(13'h0300));

        // R11: sequential read wraps the counter
        read_random(8'h1F, 8'hFE, 3, ok);
        check(rbuf[0] == pat(13'h1FFE) && rbuf[1] == pat(13'h1FFF) && rbuf[2] == pat(13'h0000),
              "R11 sequential wrap", rbuf[2], pat(13'h0000));

        // R10: current address read continues from the counter
        i2c_start(); send_byte(sel(1'b1), a);
        recv_byte(1'b0, b);
        check(a && b == pat(13'h0001), "R10 current address", b, pat(13'h0001));

        // R12: after NoAck the line stays released
        recv_byte(1'b0, b);
        check(b == 8'hFF && !sda_oe, "R12 released after noack", b, 8'hFF);
        i2c_stop();

        // R14: repeated Start mid-address restarts decoding, counter kept
        pc = push_cnt; cc = commit_cnt;
        i2c_start(); send_byte(sel(1'b0), a);
        clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
        i2c_start(); send_byte(sel(1'b1), a);
        recv_byte(1'b0, b);
        i2c_stop();
        check(a && b == pat(13'h0002), "R14 restart decode", b, pat(13'h0002));
        check(push_cnt == pc && commit_cnt == cc, "R14 nothing written", push_cnt - pc, 0);

        // Random writes and readbacks
        for (int k = 0; k < 14; k++) begin
            logic [12:0] ra;
            logic [7:0]  rd;
            ra = 13'($urandom);
            rd = 8'($urandom);
            addr_phase({3'($urandom), ra[12:8]}, ra[7:0], ok);
            send_byte(rd, a);
            i2c_stop();
            wait_idle();
            read_random({3'b000, ra[12:8]}, ra[7:0], 2, ok);
            check(ok && rbuf[0] == rd, "R5 random write readback", rbuf[0], rd);
            check(rbuf[1] == exp_rd(ra + 13'd1), "R11 random next byte",
                  rbuf[1], exp_rd(ra + 13'd1));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule